// File: doc/BRIEF.md
# Quasi-Bidirectional Eight-Bit I/O Port

This block models one general-purpose port of a small controller at register-transfer level. Each of the eight pins has a storage bit written from the internal bus. A stored 0 turns on a strong pull-down. A stored 1 releases the pin, so an outside source can drive it, or a weak internal pull-up holds it high. Software turns a pin into an input by writing 1 to it and then reading its level.

Two separate read paths return data on one registered read bus. One path samples the resolved pin levels and the other returns the stored bits. A write can also combine its operand with the stored bits using AND, OR or XOR. Because that update starts from the stored bits and not from the pins, a pin held low from outside keeps its stored 1 when other bits change.

A parameter mask selects which pins are open-drain. An open-drain pin has no internal pull-up. When such a pin is released and nothing outside drives it, it floats. This is shown by clearing that pin's `pin_known_o` bit; an outside pull-up resistor can be modelled per pin through `ext_pullup_i`.

Top module: `qbp_port`

## Requirements
- R1: When `rst_n` is low, every stored bit is set to 1 and `rd_data_o` is cleared to 0.
- R2: When `wr_i` is high with `wr_op_i` = 2'b00, the stored bits take `wr_data_i` at the clock edge. Bit k of the data goes to pin k, with bit 0 as the least significant. When `wr_i` is low, the stored bits do not change, whatever the pins do.
- R3: A pin whose stored bit is 0 has `pin_level_o` = 0 and `pin_known_o` = 1, even when an outside source drives it to 1 or pulls it up.
- R4: A pin whose stored bit is 1 and which is driven from outside (`ext_drv_en_i` bit = 1) has `pin_level_o` equal to `ext_drv_val_i` and `pin_known_o` = 1.
- R5: A pin that is not open-drain (its `OPEN_DRAIN_MASK` bit = 0; bits 7:4 by default) with stored bit 1 and no outside drive has `pin_level_o` = 1 and `pin_known_o` = 1.
- R6: An open-drain pin (its `OPEN_DRAIN_MASK` bit = 1; bits 3:0 by default) with stored bit 1 and no outside drive has `pin_level_o` = `ext_pullup_i` and `pin_known_o` = `ext_pullup_i`. A floating pin reads 0.
- R7: A cycle with `rd_pin_i` high and `rd_latch_i` low makes `rd_data_o` show, from the next edge, the pin levels present in the strobe cycle.
- R8: A cycle with `rd_latch_i` high makes `rd_data_o` show, from the next edge, the stored bits as they were in the strobe cycle. This holds even when `rd_pin_i` is also high.
- R9: In a cycle with neither read strobe high, `rd_data_o` keeps its value.
- R10: When `wr_i` is high, `wr_op_i` 2'b01, 2'b10 and 2'b11 replace the stored bits with the stored bits AND, OR or XOR `wr_data_i`. The operation uses the stored bits and never the pin levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_i | input | 1 | Write strobe for the stored bits |
| wr_op_i | input | 2 | Write operation: 00 load, 01 AND, 10 OR, 11 XOR |
| wr_data_i | input | 8 | Write data or operand |
| rd_pin_i | input | 1 | Read strobe for the pin levels |
| rd_latch_i | input | 1 | Read strobe for the stored bits |
| rd_data_o | output | 8 | Registered read data |
| ext_drv_en_i | input | 8 | Per-pin outside drive enable |
| ext_drv_val_i | input | 8 | Per-pin outside drive value |
| ext_pullup_i | input | 8 | Per-pin outside pull-up resistor present |
| pin_level_o | output | 8 | Resolved pin level |
| pin_known_o | output | 8 | Pin level is defined (not floating) |

## Verification
The assertions assume that the outside drive, pull-up and strobe inputs are stable around each rising edge. They also assume that `wr_op_i` is always one of its four codes, and that the stimulus holds every input at a known value while reset is low. The bench changes all inputs only on falling edges. It drives the write and read strobes low during reset, and it raises each strobe for exactly one cycle, so that the scoreboard can match each read result to the single strobe that caused it.

// File: rtl/qbp_pkg.sv
package qbp_pkg;

    typedef enum logic [1:0] {
        OP_LOAD = 2'b00,
        OP_AND  = 2'b01,
        OP_OR   = 2'b10,
        OP_XOR  = 2'b11
    } wr_op_e;

endpackage

// File: rtl/qbp_latch.sv
module qbp_latch
    import qbp_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  wr_op_e       op_i,
    input  logic [W-1:0] data_i,
    output logic [W-1:0] latch_o
);

    localparam logic [W-1:0] RELEASED = '1;

    typedef struct packed {
        logic [W-1:0] bits;
    } state_t;

    state_t st_d, st_q;

    // The operation always starts from the stored bits, never from the pins.
    always_comb begin
        st_d = st_q;
        if (wr_i) begin
            case (op_i)
                OP_LOAD: st_d.bits = data_i;
                OP_AND:  st_d.bits = st_q.bits & data_i;
                OP_OR:   st_d.bits = st_q.bits | data_i;
                OP_XOR:  st_d.bits = st_q.bits ^ data_i;
                default: st_d.bits = st_q.bits;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{bits: RELEASED};
        else        st_q <= st_d;
    end

    assign latch_o = st_q.bits;

    assert_hold_no_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_i) |-> $stable(latch_o));

    assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_i) && $past(op_i) == OP_LOAD) |-> latch_o == $past(data_i));

    assert_rmw_or_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_i) && $past(op_i) == OP_OR) |-> latch_o == ($past(latch_o) | $past(data_i)));

endmodule

// File: rtl/qbp_pin_resolve.sv
module qbp_pin_resolve #(
    parameter int           W       = 8,
    parameter logic [W-1:0] OD_MASK = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] latch_i,
    input  logic [W-1:0] ext_en_i,
    input  logic [W-1:0] ext_val_i,
    input  logic [W-1:0] ext_pu_i,
    output logic [W-1:0] level_o,
    output logic [W-1:0] known_o
);

    for (genvar i = 0; i < W; i++) begin : g_pin
        logic sink_low;
        logic src_high;

        // Either the stored 0 or an outside 0 wins against any pull-up.
        assign sink_low = ~latch_i[i] | (ext_en_i[i] & ~ext_val_i[i]);

        if (OD_MASK[i]) begin : g_open_drain
            assign src_high = (ext_en_i[i] & ext_val_i[i]) | ext_pu_i[i];
        end else begin : g_pulled
            assign src_high = 1'b1;
        end

        assign level_o[i] = ~sink_low & src_high;
        assign known_o[i] = sink_low | src_high;
    end

    assert_stored_zero_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(~latch_i & level_o)));

    assert_follow_drive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        &(~(latch_i & ext_en_i) | ~(level_o ^ ext_val_i)));

    assert_pulled_known_R5: assert property (@(posedge clk) disable iff (!rst_n)
        &(known_o | OD_MASK));

endmodule

// File: rtl/qbp_readback.sv
module qbp_readback #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rd_pin_i,
    input  logic         rd_latch_i,
    input  logic [W-1:0] pin_level_i,
    input  logic [W-1:0] latch_i,
    output logic [W-1:0] rd_data_o
);

    typedef struct packed {
        logic [W-1:0] data;
    } state_t;

    state_t st_d, st_q;

    // The stored-bit path takes priority when both strobes arrive together.
    always_comb begin
        st_d = st_q;
        if (rd_latch_i)    st_d.data = latch_i;
        else if (rd_pin_i) st_d.data = pin_level_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{data: '0};
        else        st_q <= st_d;
    end

    assign rd_data_o = st_q.data;

    assert_pin_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rd_pin_i) && !$past(rd_latch_i)) |-> rd_data_o == $past(pin_level_i));

    assert_latch_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_latch_i) |-> rd_data_o == $past(latch_i));

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(rd_pin_i) && !$past(rd_latch_i)) |-> $stable(rd_data_o));

endmodule

// File: rtl/qbp_port.sv
module qbp_port
    import qbp_pkg::*;
#(
    parameter int               PORT_W          = 8,
    parameter logic [PORT_W-1:0] OPEN_DRAIN_MASK = 8'h0F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [1:0]        wr_op_i,
    input  logic [PORT_W-1:0] wr_data_i,
    input  logic              rd_pin_i,
    input  logic              rd_latch_i,
    output logic [PORT_W-1:0] rd_data_o,
    input  logic [PORT_W-1:0] ext_drv_en_i,
    input  logic [PORT_W-1:0] ext_drv_val_i,
    input  logic [PORT_W-1:0] ext_pullup_i,
    output logic [PORT_W-1:0] pin_level_o,
    output logic [PORT_W-1:0] pin_known_o
);

    logic [PORT_W-1:0] latch_w;
    logic [PORT_W-1:0] level_w;

    qbp_latch #(.W(PORT_W)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (wr_i),
        .op_i    (wr_op_e'(wr_op_i)),
        .data_i  (wr_data_i),
        .latch_o (latch_w)
    );

    qbp_pin_resolve #(.W(PORT_W), .OD_MASK(OPEN_DRAIN_MASK)) u_resolve (
        .clk       (clk),
        .rst_n     (rst_n),
        .latch_i   (latch_w),
        .ext_en_i  (ext_drv_en_i),
        .ext_val_i (ext_drv_val_i),
        .ext_pu_i  (ext_pullup_i),
        .level_o   (level_w),
        .known_o   (pin_known_o)
    );

    qbp_readback #(.W(PORT_W)) u_readback (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_pin_i    (rd_pin_i),
        .rd_latch_i  (rd_latch_i),
        .pin_level_i (level_w),
        .latch_i     (latch_w),
        .rd_data_o   (rd_data_o)
    );

    assign pin_level_o = level_w;

endmodule

// File: tb/qbp_port_tb.sv
`timescale 1ns/1ps
module qbp_port_tb;

    localparam logic [7:0] OD = 8'h0F;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_i = 1'b0;
    logic [1:0] wr_op_i = 2'b00;
    logic [7:0] wr_data_i = 8'h00;
    logic       rd_pin_i = 1'b0;
    logic       rd_latch_i = 1'b0;
    logic [7:0] rd_data_o;
    logic [7:0] ext_drv_en_i = 8'h00;
    logic [7:0] ext_drv_val_i = 8'h00;
    logic [7:0] ext_pullup_i = 8'h00;
    logic [7:0] pin_level_o;
    logic [7:0] pin_known_o;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [7:0] m_latch = 8'hFF;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic       cap = 1'b0;

    always #2 clk = ~clk;

    qbp_port u_dut (
        .clk(clk), .rst_n(rst_n), .wr_i(wr_i), .wr_op_i(wr_op_i),
        .wr_data_i(wr_data_i), .rd_pin_i(rd_pin_i), .rd_latch_i(rd_latch_i),
        .rd_data_o(rd_data_o), .ext_drv_en_i(ext_drv_en_i),
        .ext_drv_val_i(ext_drv_val_i), .ext_pullup_i(ext_pullup_i),
        .pin_level_o(pin_level_o), .pin_known_o(pin_known_o)
    );

    function automatic logic [7:0] exp_level(input logic [7:0] l);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) begin
            logic lo, hi;
            lo = !l[i] || (ext_drv_en_i[i] && !ext_drv_val_i[i]);
            hi = !OD[i] || (ext_drv_en_i[i] && ext_drv_val_i[i]) || ext_pullup_i[i];
            r[i] = !lo && hi;
        end
        return r;
    endfunction

    function automatic logic [7:0] exp_known(input logic [7:0] l);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) begin
            logic lo, hi;
            lo = !l[i] || (ext_drv_en_i[i] && !ext_drv_val_i[i]);
            hi = !OD[i] || (ext_drv_en_i[i] && ext_drv_val_i[i]) || ext_pullup_i[i];
            r[i] = lo || hi;
        end
        return r;
    endfunction

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [1:0] op, input logic [7:0] d);
        wr_i = 1'b1; wr_op_i = op; wr_data_i = d;
        tick();
        wr_i = 1'b0;
        case (op)
            2'b00: m_latch = d;
            2'b01: m_latch = m_latch & d;
            2'b10: m_latch = m_latch | d;
            default: m_latch = m_latch ^ d;
        endcase
    endtask

    task automatic do_read(input bit pin_sel, input bit lat_sel, input string tag);
        exp_q.push_back(lat_sel ? m_latch : exp_level(m_latch));
        tag_q.push_back(tag);
        rd_pin_i = pin_sel; rd_latch_i = lat_sel;
        tick();
        rd_pin_i = 1'b0; rd_latch_i = 1'b0;
    endtask

    task automatic check_pins(input string tag);
        check({tag, " level"}, pin_level_o, exp_level(m_latch));
        check({tag, " known"}, pin_known_o, exp_known(m_latch));
    endtask

    // Monitor: a strobe seen at an edge is compared at the following falling edge.
    always @(posedge clk) cap <= rd_pin_i | rd_latch_i;

    always @(negedge clk) begin
        if (cap && exp_q.size() > 0) begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, rd_data_o, e);
        end
    end

    initial begin
        logic [7:0] held;
        repeat (3) tick();
        check("R1 read data after reset", rd_data_o, 8'h00);
        rst_n = 1'b1;
        tick();
        do_read(1'b0, 1'b1, "R1 stored bits after reset");

        // Released pins, nothing outside: pulled pins high, open-drain floats
        check_pins("R5/R6 undriven no pull-up");
        check("R6 floating reads 0 known 0", pin_known_o & OD, 8'h00);
        ext_pullup_i = 8'hFF; #0;
        check_pins("R6 open-drain with outside pull-up");
        do_read(1'b1, 1'b0, "R6 pin read with pull-up");
        ext_pullup_i = 8'h00;

        // Load and pin pull-down against outside 1
        do_write(2'b00, 8'hA5);
        do_read(1'b0, 1'b1, "R2 load A5");
        ext_drv_en_i = 8'hFF; ext_drv_val_i = 8'hFF; #0;
        check("R3 stored zeros win over outside 1", pin_level_o, 8'hA5);
        check_pins("R3 pins");

        // Input use: release all then follow outside drive
        do_write(2'b00, 8'hFF);
        ext_drv_val_i = 8'h3C; #0;
        check("R4 pins follow outside drive", pin_level_o, 8'h3C);
        do_read(1'b1, 1'b0, "R7 pin read 3C");
        ext_drv_en_i = 8'h0F; ext_drv_val_i = 8'h00; #0;
        check_pins("R4/R5 low nibble driven low");
        do_read(1'b1, 1'b0, "R7 pin read F0");

        // Stored bits unaffected by pin activity without a write
        do_read(1'b0, 1'b1, "R2 no write keeps FF");

        // Read-modify-write on stored bits while low nibble is held low outside
        do_write(2'b10, 8'h80);
        do_read(1'b0, 1'b1, "R10 OR keeps held-low bits at 1");
        do_write(2'b01, 8'h0F);
        do_read(1'b0, 1'b1, "R10 AND");
        do_write(2'b11, 8'hFF);
        do_read(1'b0, 1'b1, "R10 XOR");
        check_pins("R3 after XOR");

        // Both strobes: stored path wins
        do_write(2'b00, 8'h5A);
        ext_drv_en_i = 8'h00; #0;
        do_read(1'b1, 1'b1, "R8 both strobes");

        // Hold with no strobe
        tick();
        held = rd_data_o;
        ext_drv_en_i = 8'hFF; ext_drv_val_i = 8'h00;
        repeat (3) tick();
        check("R9 read data held", rd_data_o, held);

        // Bit ordering: single bit 0 loaded
        ext_drv_en_i = 8'h00;
        do_write(2'b00, 8'h01);
        do_read(1'b0, 1'b1, "R2 bit 0 is LSB");
        ext_pullup_i = 8'h01; #0;
        do_read(1'b1, 1'b0, "R6 pin read bit0 pulled outside");

        repeat (3) tick();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule